// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the host-visible register set of a two-channel disk bus-master DMA controller. It sits on an I/O window of 16 bytes, one 8-byte slice per channel. Each slice holds a command byte, a status byte and a 32-bit pointer to the transfer engine's descriptor table. The host bus reaches it through a single-cycle access strobe with an address, an access size and write data. Read data is combinational from address and size.

The command byte drives the engine's run and direction controls. Clearing the run bit produces a one-cycle stop pulse. The status byte combines three kinds of bit: an activity bit that follows the engine's busy line, host-writable flag bits, and interrupt and error flags. The engine sets the flags with one-cycle events, and the host clears them by writing a one. Only byte accesses reach the command and status registers. Every other access size to that region reads as all ones and changes nothing.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset every register of both channels is zero, so reads of command, status and pointer return 0, and start_o, dir_o, stop_o and tbl_ptr_o are all 0.
- R2: Channel n's command byte sits at offset n*8 and its status byte at n*8+2. Byte reads at n*8+1 and n*8+3 return 0xFF, and byte writes there change nothing.
- R3: The access size is encoded as size_i = 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 as reserved. A read of size 1, 2 or 3 at offsets n*8+0..3 returns 0x0000FFFF for size 1 and 0xFFFFFFFF for sizes 2 and 3. A byte-wide result sits in rdata_o[7:0] with the upper bits zero.
- R4: A write of size 1, 2 or 3 to offsets n*8+0..3 leaves the command and status bytes unchanged.
- R5: On a byte write to status, bits 6 and 5 take the written value and bit 0 keeps its value. Bits 2 and 1 clear where the data bit is 1 and hold where it is 0. Bits 7, 4 and 3 always read 0.
- R6: A byte write to command stores all 8 bits, and a read returns them. start_o follows bit 0 and dir_o follows bit 3. When a write changes bit 0 from 1 to 0, stop_o is high for exactly the cycle after the write edge.
- R7: Status bit 0 shows busy_i as sampled on the previous clock edge.
- R8: A pulse on irq_ev_i sets status bit 2 and a pulse on err_ev_i sets status bit 1. The event wins over a write-one-to-clear in the same cycle.
- R9: A size-2 write at n*8+4 stores the pointer with bits 1:0 forced to 0, and a size-2 read there returns it. Any other size or offset within n*8+4..7 reads as all ones across the access width and ignores writes.
- R10: An access to one channel's slice never changes the other channel's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (4) | Byte offset within the window |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| wdata_i | input | 32 | Write data, least significant byte first |
| rdata_o | output | 32 | Read data, combinational from addr_i and size_i |
| busy_i | input | NUM_CH | Engine busy, per channel |
| irq_ev_i | input | NUM_CH | One-cycle interrupt event, per channel |
| err_ev_i | input | NUM_CH | One-cycle error event, per channel |
| start_o | output | NUM_CH | Run control (command bit 0) |
| dir_o | output | NUM_CH | Direction control (command bit 3) |
| stop_o | output | NUM_CH | One-cycle pulse when run is cleared |
| tbl_ptr_o | output | NUM_CH*32 | Descriptor-table pointers, channel 0 in the low word |

## Verification
The bench sweeps all 256 status write values from alternating pre-states, which catches a design that clears bits 1 and 2 on a written zero, lets bit 0 be overwritten, or leaks bits 7, 4 or 3. It sweeps all 256 command values and checks the stop pulse against the previous run bit, which catches a pulse that fires on any write or lasts two cycles. Every non-byte size and every dead byte offset is read and written with all-ones data while the live registers hold known values. A decoder that ignores size_i would then return stored data or corrupt the command and clear the flags. An event asserted in the same cycle as a clearing write checks that the flag survives, and the busy mirror is sampled before and after an edge to pin its one-cycle delay.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int SLICE_B = 8;
  localparam int PTR_W   = 32;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_R = 2'd3} acc_size_e;
  typedef enum logic [1:0] {RD_CMD, RD_STS, RD_PTR, RD_ONES} rd_kind_e;

  function automatic logic [31:0] ones_mask(input acc_size_e s);
    case (s)
      SZ_B:    return 32'h0000_00ff;
      SZ_H:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int ADDR_W = $clog2(NUM_CH * SLICE_B),
  localparam int CH_W = ADDR_W - 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [NUM_CH-1:0] cmd_we_o,
  output logic [NUM_CH-1:0] sts_we_o,
  output logic [NUM_CH-1:0] ptr_we_o,
  output rd_kind_e          rd_kind_o,
  output logic [CH_W-1:0]   rd_ch_o
);
  logic [CH_W-1:0] ch_idx;
  logic [2:0]      off;
  logic            ch_ok, is_byte, is_word, wr;

  assign ch_idx  = addr_i[ADDR_W-1:3];
  assign off     = addr_i[2:0];
  assign ch_ok   = int'(ch_idx) < NUM_CH;
  assign is_byte = size_i == SZ_B;
  assign is_word = size_i == SZ_W;
  assign wr      = req_i && we_i && ch_ok;
  assign rd_ch_o = ch_idx;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_we
    logic hit;
    assign hit         = wr && (int'(ch_idx) == g);
    assign cmd_we_o[g] = hit && is_byte && off == 3'd0;
    assign sts_we_o[g] = hit && is_byte && off == 3'd2;
    assign ptr_we_o[g] = hit && is_word && off == 3'd4;
  end

  always_comb begin
    rd_kind_o = RD_ONES;
    if (ch_ok) begin
      if (!off[2]) begin
        if (is_byte && off[1:0] == 2'd0)      rd_kind_o = RD_CMD;
        else if (is_byte && off[1:0] == 2'd2) rd_kind_o = RD_STS;
      end else if (is_word && off == 3'd4) begin
        rd_kind_o = RD_PTR;
      end
    end
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic             sts_we_i,
  input  logic             ptr_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             busy_i,
  input  logic             irq_ev_i,
  input  logic             err_ev_i,
  output logic [7:0]       cmd_o,
  output logic [7:0]       sts_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             start_o,
  output logic             dir_o,
  output logic             stop_o
);
  logic [7:0]       cmd_q;
  logic [PTR_W-1:0] ptr_q;
  logic             act_q, err_q, irq_q, f5_q, f6_q, stop_q;
  logic             irq_clr, err_clr;

  assign irq_clr = sts_we_i && wdata_i[2];
  assign err_clr = sts_we_i && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      ptr_q  <= '0;
      act_q  <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      f5_q   <= 1'b0;
      f6_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      act_q  <= busy_i;
      stop_q <= cmd_we_i && cmd_q[0] && !wdata_i[0];
      if (cmd_we_i) cmd_q <= wdata_i[7:0];
      if (ptr_we_i) ptr_q <= {wdata_i[PTR_W-1:2], 2'b00};
      if (sts_we_i) begin
        f5_q <= wdata_i[5];
        f6_q <= wdata_i[6];
      end
      // set event beats a same-cycle clear
      irq_q <= irq_ev_i || (irq_q && !irq_clr);
      err_q <= err_ev_i || (err_q && !err_clr);
    end
  end

  assign cmd_o   = cmd_q;
  assign sts_o   = {1'b0, f6_q, f5_q, 2'b00, irq_q, err_q, act_q};
  assign ptr_o   = ptr_q;
  assign start_o = cmd_q[0];
  assign dir_o   = cmd_q[3];
  assign stop_o  = stop_q;

  assert_irq_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ev_i |=> sts_o[2]);
  assert_err_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev_i |=> sts_o[1]);
  assert_w1c_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && wdata_i[2] && !irq_ev_i) |=> !sts_o[2]);
  assert_stop_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_o) |-> stop_o);
  assert_busy_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> sts_o[0]);
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int ADDR_W = $clog2(NUM_CH * SLICE_B)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic [NUM_CH-1:0]       busy_i,
  input  logic [NUM_CH-1:0]       irq_ev_i,
  input  logic [NUM_CH-1:0]       err_ev_i,
  output logic [NUM_CH-1:0]       start_o,
  output logic [NUM_CH-1:0]       dir_o,
  output logic [NUM_CH-1:0]       stop_o,
  output logic [NUM_CH*PTR_W-1:0] tbl_ptr_o
);
  localparam int CH_W = ADDR_W - 3;

  logic [NUM_CH-1:0] cmd_we, sts_we, ptr_we;
  rd_kind_e          rd_kind;
  logic [CH_W-1:0]   rd_ch;
  logic [7:0]        cmd_a [NUM_CH];
  logic [7:0]        sts_a [NUM_CH];
  logic [PTR_W-1:0]  ptr_a [NUM_CH];

  bmdma_decode #(.NUM_CH(NUM_CH)) u_decode (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .size_i   (size_i),
    .cmd_we_o (cmd_we),
    .sts_we_o (sts_we),
    .ptr_we_o (ptr_we),
    .rd_kind_o(rd_kind),
    .rd_ch_o  (rd_ch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    bmdma_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmd_we_i(cmd_we[g]),
      .sts_we_i(sts_we[g]),
      .ptr_we_i(ptr_we[g]),
      .wdata_i (wdata_i),
      .busy_i  (busy_i[g]),
      .irq_ev_i(irq_ev_i[g]),
      .err_ev_i(err_ev_i[g]),
      .cmd_o   (cmd_a[g]),
      .sts_o   (sts_a[g]),
      .ptr_o   (ptr_a[g]),
      .start_o (start_o[g]),
      .dir_o   (dir_o[g]),
      .stop_o  (stop_o[g])
    );
    assign tbl_ptr_o[g*PTR_W +: PTR_W] = ptr_a[g];
  end

  always_comb begin
    case (rd_kind)
      RD_CMD:  rdata_o = {24'h0, cmd_a[rd_ch]};
      RD_STS:  rdata_o = {24'h0, sts_a[rd_ch]};
      RD_PTR:  rdata_o = ptr_a[rd_ch];
      default: rdata_o = ones_mask(acc_size_e'(size_i));
    endcase
  end

  assert_wide_wr_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != SZ_B && !addr_i[2]) |=> ($stable(start_o) && $stable(dir_o)));
endmodule

// File: tb/bmdma_regfile_bench.sv
`timescale 1ns/1ps
module bmdma_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  busy = '0, irq_ev = '0, err_ev = '0;
  logic [1:0]  start, dir, stop;
  logic [63:0] tbl_ptr;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bmdma_regfile u_bmdma_regfile (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy),
    .irq_ev_i(irq_ev), .err_ev_i(err_ev), .start_o(start), .dir_o(dir),
    .stop_o(stop), .tbl_ptr_o(tbl_ptr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] mask(input int sz);
    return (sz == 0) ? 32'hff : (sz == 1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  task automatic wr(input int a, input int sz, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = 4'(a); size = 2'(sz); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, input int sz, output logic [31:0] q);
    req = 1'b1; we = 1'b0; addr = 4'(a); size = 2'(sz);
    #1 q = rdata;
    req = 1'b0;
  endtask

  task automatic pulse(input int ch, input logic i, input logic e);
    irq_ev[ch] = i; err_ev[ch] = e;
    @(negedge clk);
    irq_ev = '0; err_ev = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] q, exp;
    logic [7:0]  prev, pre;
    logic        b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 2; c++) begin
      rd(c*8, 0, q);   chk("R1 cmd", q, 0);
      rd(c*8+2, 0, q); chk("R1 sts", q, 0);
      rd(c*8+4, 2, q); chk("R1 ptr", q, 0);
    end
    chk("R1 outs", {26'h0, start, dir, stop}, 0);
    chk("R1 ptr_o", tbl_ptr[31:0] | tbl_ptr[63:32], 0);

    // R5 status sweep, channel 0
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      b = v[3] ^ v[0];
      busy[0] = b;
      if (v[7]) begin
        pulse(0, 1'b1, 1'b1);
        pre = 8'h06;
      end else begin
        @(negedge clk);
        pre = prev & 8'h06;
      end
      wr(2, 0, 32'(v));
      exp = 32'((v & 8'h60) | {7'h0, b} | (pre & ~8'(v) & 8'h06));
      rd(2, 0, q);
      chk("R5 sts sweep", q, exp);
      prev = exp[7:0];
    end
    busy[0] = 1'b0;
    rd(10, 0, q); chk("R10 ch1 sts untouched", q, 0);

    // R6 command sweep, channel 1
    prev = 8'h00;
    for (int v = 0; v < 256; v++) begin
      wr(8, 0, 32'(v));
      chk("R6 stop pulse", 32'(stop[1]), 32'(prev[0] & ~v[0]));
      chk("R6 start/dir", {30'h0, dir[1], start[1]}, {30'h0, v[3], v[0]});
      chk("R10 ch0 stop", 32'(stop[0]), 0);
      rd(8, 0, q); chk("R6 cmd readback", q, 32'(v));
      if (prev[0] && !v[0]) begin
        @(negedge clk);
        chk("R6 stop one cycle", 32'(stop[1]), 0);
      end
      prev = 8'(v);
    end
    rd(0, 0, q); chk("R10 ch0 cmd untouched", q, 0);

    // known state for ignored-access checks
    wr(0, 0, 32'h09);
    wr(8, 0, 32'h08);
    wr(2, 0, 32'h20);
    wr(10, 0, 32'h40);
    irq_ev = 2'b11; @(negedge clk); irq_ev = '0;
    rd(2, 0, q);  chk("R8 irq set ch0", q, 32'h24);
    rd(10, 0, q); chk("R8 irq set ch1", q, 32'h44);

    // R2 R3 R4 dead offsets and non-byte sizes
    for (int c = 0; c < 2; c++) begin
      for (int off = 0; off < 4; off++) begin
        for (int sz = 0; sz < 4; sz++) begin
          if (sz == 0 && (off == 0 || off == 2)) continue;
          rd(c*8+off, sz, q);
          chk(sz == 0 ? "R2 dead byte read" : "R3 wide read ones", q, mask(sz));
          wr(c*8+off, sz, 32'hffff_ffff);
          rd(c*8, 0, q);
          chk(sz == 0 ? "R2 dead write cmd" : "R4 wide write cmd", q, c == 0 ? 32'h09 : 32'h08);
          rd(c*8+2, 0, q);
          chk(sz == 0 ? "R2 dead write sts" : "R4 wide write sts", q, c == 0 ? 32'h24 : 32'h44);
          chk("R4 stop quiet", 32'(stop), 0);
        end
      end
    end

    // R9 pointer
    wr(4, 2, 32'hdead_beef);
    chk("R9 ptr_o ch0", tbl_ptr[31:0], 32'hdead_beec);
    rd(4, 2, q); chk("R9 ptr read ch0", q, 32'hdead_beec);
    wr(12, 2, 32'h1234_5677);
    rd(12, 2, q); chk("R9 ptr read ch1", q, 32'h1234_5674);
    chk("R10 ch0 ptr kept", tbl_ptr[31:0], 32'hdead_beec);
    for (int off = 4; off < 8; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        if (off == 4 && sz == 2) continue;
        rd(off, sz, q); chk("R9 ptr region ones", q, mask(sz));
        wr(off, sz, 32'h0);
        chk("R9 ptr write ignored", tbl_ptr[31:0], 32'hdead_beec);
      end
    end

    // R8 event beats same-cycle clear
    irq_ev[1] = 1'b1; wr(10, 0, 32'h04); irq_ev = '0;
    rd(10, 0, q); chk("R8 irq priority", q & 32'h04, 32'h04);
    wr(10, 0, 32'h04);
    rd(10, 0, q); chk("R5 irq clear", q & 32'h04, 0);
    err_ev[1] = 1'b1; wr(10, 0, 32'h02); err_ev = '0;
    rd(10, 0, q); chk("R8 err priority", q & 32'h02, 32'h02);
    wr(10, 0, 32'h02);
    rd(10, 0, q); chk("R5 err clear", q & 32'h02, 0);

    // R7 busy mirror delay
    busy[1] = 1'b1;
    rd(10, 0, q); chk("R7 busy before edge", q & 32'h01, 0);
    @(negedge clk);
    rd(10, 0, q); chk("R7 busy after edge", q & 32'h01, 1);
    busy[1] = 1'b0;
    @(negedge clk);
    rd(10, 0, q); chk("R7 busy drop", q & 32'h01, 0);
    rd(2, 0, q);  chk("R10 ch0 busy quiet", q & 32'h01, 0);

    summary();
  end
endmodule